// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire bus master and frees the bus when a slave device has been left holding the data line low. The usual causes are an interrupted transfer, a brown-out or a reset of the master alone. When the caller raises a recover request, the sequencer takes over both open-drain lines. It produces up to a bounded number of clock pulses with the data line released, and samples the data line near the end of every clock-high phase.

Once the data line reads high, the sequencer holds the clock high for a setup interval. It then pulls the data line low while the clock is still high, which is a start condition, and holds it there for a hold interval. Finally it drives the clock low and flags completion for one cycle, so that the normal master can take over in the middle of a fresh transaction. If the data line is still low after the last permitted pulse, the sequencer releases both lines and flags failure instead.

All phase lengths are counts of system-clock cycles. They are computed from the system clock frequency in MHz and from the minimum bus timings in nanoseconds, rounded up. The `sda_i` input is expected to be already synchronised to `clk_i`.

Top module: `bus_recover`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `done_o` and `fail_o` are all 0.
- R2: A `recover_i` seen high while idle starts a clock-low phase. In that phase `scl_oe_o`=1 and `sda_oe_o`=0 for exactly LOW_CYC = ceil(T_LOW_NS*CLK_MHZ/1000) cycles.
- R3: Each clock-high phase keeps `scl_oe_o`=0 for HIGH_CYC = ceil(T_HIGH_NS*CLK_MHZ/1000) cycles. `sda_oe_o` stays 0 during every low and high phase of the clocking loop.
- R4: `sda_i` is sampled in the last cycle of each high phase. If it reads 1, no further clock pulse is issued. If it reads 0, a new low phase follows immediately.
- R5: At most MAX_PULSES (default 9) high phases are issued. If `sda_i` reads 0 at the end of the last one, `fail_o`=1 for one cycle with both enables at 0, and the block then returns to idle.
- R6: After `sda_i` reads 1, the clock stays released for a further SU_CYC cycles with `sda_oe_o`=0. Then `sda_oe_o`=1 while `scl_oe_o`=0 for HD_CYC cycles, which forms the start condition.
- R7: The start condition is followed by exactly one cycle with `scl_oe_o`=1, `sda_oe_o`=1 and `done_o`=1. After that cycle both enables return to 0 in idle.
- R8: `recover_i` has no effect while a sequence is in progress. Phase lengths and pulse count are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recover_i | input | 1 | Start a recovery sequence (sampled while idle) |
| sda_i | input | 1 | Synchronised level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| done_o | output | 1 | One-cycle pulse: start condition issued, lines handed over |
| fail_o | output | 1 | One-cycle pulse: data line still low after the last pulse |

## Verification
The bench models a slave that keeps the data line low until it has seen a chosen number of clock rising edges. The cases are a slave that never holds the line, one that lets go after a few pulses, one that lets go exactly on the final permitted pulse, and one that never lets go.

Each recorded run of output levels is checked against an expected list, with its length in cycles. An off-by-one in the pulse bound shows up as a spurious fail or a tenth pulse. A wrong sample point shows up as an extra or a missing pulse. A start condition issued with the clock low appears as a reordered segment. Extra recover requests sent during a sequence expose a design that restarts or stretches a phase.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETUP,
    ST_HOLD,
    ST_DONE,
    ST_FAIL
  } rec_state_e;

  // cycles covering ns at mhz, rounded up, at least 1
  function automatic int ns_to_cycles(int ns, int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/rec_phase_timer.sv
module rec_phase_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // a running count only moves downward by one
  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rec_pulse_counter.sv
module rec_pulse_counter #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_PULSES - 1));

  p_pulse_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_PULSES));

  p_no_inc_on_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> !last_o);

endmodule

// File: rtl/rec_fsm.sv
module rec_fsm
  import bus_recover_pkg::*;
#(
  parameter int W      = 9,
  parameter int LOW_CYC  = 325,
  parameter int HIGH_CYC = 175,
  parameter int SU_CYC   = 175,
  parameter int HD_CYC   = 175
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         recover_i,
  input  logic         sda_i,
  input  logic         expired_i,
  input  logic         last_pulse_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         pulse_clr_o,
  output logic         pulse_inc_o,
  output logic         scl_oe_o,
  output logic         sda_oe_o,
  output logic         done_o,
  output logic         fail_o
);

  localparam logic [W-1:0] LowLd  = W'(LOW_CYC - 1);
  localparam logic [W-1:0] HighLd = W'(HIGH_CYC - 1);
  localparam logic [W-1:0] SuLd   = W'(SU_CYC - 1);
  localparam logic [W-1:0] HdLd   = W'(HD_CYC - 1);

  rec_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    load_val_o  = '0;
    pulse_clr_o = 1'b0;
    pulse_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (recover_i) begin
        state_d = ST_LOW; load_o = 1'b1; load_val_o = LowLd; pulse_clr_o = 1'b1;
      end
      ST_LOW: if (expired_i) begin
        state_d = ST_HIGH; load_o = 1'b1; load_val_o = HighLd;
      end
      ST_HIGH: if (expired_i) begin
        if (sda_i) begin
          state_d = ST_SETUP; load_o = 1'b1; load_val_o = SuLd;
        end else if (last_pulse_i) begin
          state_d = ST_FAIL;
        end else begin
          state_d = ST_LOW; load_o = 1'b1; load_val_o = LowLd; pulse_inc_o = 1'b1;
        end
      end
      ST_SETUP: if (expired_i) begin
        state_d = ST_HOLD; load_o = 1'b1; load_val_o = HdLd;
      end
      ST_HOLD: if (expired_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_FAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_DONE);
  assign sda_oe_o = (state_q == ST_HOLD) || (state_q == ST_DONE);
  assign done_o   = (state_q == ST_DONE);
  assign fail_o   = (state_q == ST_FAIL);

  // start condition: data falls only with the clock released
  p_start_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_oe_o);

  p_done_after_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(sda_oe_o) && !$past(scl_oe_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !scl_oe_o && !sda_oe_o));

  p_fail_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> (!fail_o && !scl_oe_o && !sda_oe_o));

  p_fail_after_low_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (!$past(sda_i) && !$past(scl_oe_o)));

  p_busy_ignores_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIGH && !expired_i) |=> (state_q == ST_HIGH));

endmodule

// File: rtl/bus_recover.sv
module bus_recover
  import bus_recover_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int T_LOW_NS   = 1300,
  parameter int T_HIGH_NS  = 700,
  parameter int T_SU_NS    = 700,
  parameter int T_HD_NS    = 700,
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recover_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic done_o,
  output logic fail_o
);

  localparam int LowCyc  = ns_to_cycles(T_LOW_NS, CLK_MHZ);
  localparam int HighCyc = ns_to_cycles(T_HIGH_NS, CLK_MHZ);
  localparam int SuCyc   = ns_to_cycles(T_SU_NS, CLK_MHZ);
  localparam int HdCyc   = ns_to_cycles(T_HD_NS, CLK_MHZ);
  localparam int MaxA    = (LowCyc > HighCyc) ? LowCyc : HighCyc;
  localparam int MaxB    = (SuCyc > HdCyc) ? SuCyc : HdCyc;
  localparam int MaxCyc  = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int TW      = $clog2(MaxCyc + 1);

  logic          load;
  logic [TW-1:0] load_val;
  logic          expired;
  logic          pulse_clr, pulse_inc, last_pulse;

  rec_phase_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  rec_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pulse_clr),
    .inc_i  (pulse_inc),
    .last_o (last_pulse)
  );

  rec_fsm #(
    .W        (TW),
    .LOW_CYC  (LowCyc),
    .HIGH_CYC (HighCyc),
    .SU_CYC   (SuCyc),
    .HD_CYC   (HdCyc)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .recover_i    (recover_i),
    .sda_i        (sda_i),
    .expired_i    (expired),
    .last_pulse_i (last_pulse),
    .load_o       (load),
    .load_val_o   (load_val),
    .pulse_clr_o  (pulse_clr),
    .pulse_inc_o  (pulse_inc),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
  );

  // clocking loop never drives data
  p_sda_free_while_clocking_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !done_o) |-> !sda_oe_o);

  p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

endmodule

// File: tb/bus_recover_tb.sv
module bus_recover_tb;

  localparam int MHZ  = 250;
  localparam int MAXP = 9;
  localparam int WD_CYCLES = 150000;

  function automatic int cyc(int ns);
    return (ns * MHZ + 999) / 1000;
  endfunction

  localparam int TL  = cyc(1300);
  localparam int TH  = cyc(700);
  localparam int TSU = cyc(700);
  localparam int THD = cyc(700);

  typedef struct {
    logic [3:0] sig;   // {scl_oe, sda_oe, done, fail}
    int         len;   // 0 = any length
    string      req;
  } seg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover = 1'b0;
  logic scl_oe, sda_oe, done, fail;
  logic sda_line;

  int slave_k = 0;
  int slave_rises = 0;
  int slave_base = 0;
  logic slave_hold;
  logic scl_prev = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  seg_t exp_q[$];
  logic [3:0] run_sig = 4'b0000;
  int run_len = 0;

  always #2 clk = ~clk;

  assign slave_hold = (slave_rises - slave_base) < slave_k;
  assign sda_line   = !(slave_hold || sda_oe);

  bus_recover u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .recover_i (recover),
    .sda_i     (sda_line),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe),
    .done_o    (done),
    .fail_o    (fail)
  );

  // slave model: counts rising edges of the clock line
  always @(negedge clk) begin
    if (rst_n && scl_prev == 1'b0 && !scl_oe) slave_rises <= slave_rises + 1;
    scl_prev <= !scl_oe;
  end

  // monitor: compares each finished run of output levels to the queue
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] cur;
      cur = {scl_oe, sda_oe, done, fail};
      if (cur == run_sig) begin
        run_len <= run_len + 1;
      end else begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected segment sig=%b len=%0d expected none", run_sig, run_len);
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          if (e.sig != run_sig || (e.len != 0 && e.len != run_len)) begin
            n_fail++;
            $display("FAIL %s segment sig=%b len=%0d expected sig=%b len=%0d",
                     e.req, run_sig, run_len, e.sig, e.len);
          end
        end
        run_sig <= cur;
        run_len <= 1;
      end
    end
  end

  task automatic push(logic [3:0] s, int l, string r);
    seg_t e;
    e.sig = s; e.len = l; e.req = r;
    exp_q.push_back(e);
  endtask

  // expected runs for a slave that releases on rising edge k
  task automatic expect_seq(int k, string tag);
    int pulses;
    bit ok;
    ok = (k <= MAXP);
    pulses = ok ? ((k < 1) ? 1 : k) : MAXP;
    push(4'b0000, 0, {"R1/", tag});
    for (int i = 1; i <= pulses; i++) begin
      push(4'b1000, TL, {"R2/", tag});
      if (i < pulses) push(4'b0000, TH, {"R3/R4/", tag});
    end
    if (ok) begin
      push(4'b0000, TH + TSU, {"R4/R6/", tag});
      push(4'b0100, THD, {"R6/", tag});
      push(4'b1110, 1, {"R7/", tag});
    end else begin
      push(4'b0000, TH, {"R5/", tag});
      push(4'b0001, 1, {"R5/", tag});
    end
  endtask

  task automatic run(int k, bit poke, string tag);
    expect_seq(k, tag);
    @(negedge clk);
    slave_base = slave_rises;
    slave_k = k;
    recover = 1'b1;
    @(negedge clk);
    recover = 1'b0;
    if (poke) begin
      // R8: extra requests in low and in high phases
      repeat (100) @(negedge clk);
      recover = 1'b1;
      repeat (3) @(negedge clk);
      recover = 1'b0;
      repeat (TL + 20) @(negedge clk);
      recover = 1'b1;
      @(negedge clk);
      recover = 1'b0;
    end
    while (!(done || fail)) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_CYCLES) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < %0d", cycles, WD_CYCLES);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if ({scl_oe, sda_oe, done, fail} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 outputs in reset %b expected 0000", {scl_oe, sda_oe, done, fail});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if ({scl_oe, sda_oe, done, fail} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1 outputs after reset %b expected 0000", {scl_oe, sda_oe, done, fail});
    end

    run(0, 1'b0, "free bus");
    run(3, 1'b0, "release on 3");
    run(MAXP, 1'b0, "release on last");
    run(MAXP + 1, 1'b0, "stuck");
    run(1, 1'b0, "after fail");
    run(2, 1'b1, "R8 pokes");
    run(MAXP + 1, 1'b1, "R8 stuck pokes");

    // close the trailing idle run is not needed; all other runs consumed
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 leftover expected segments %0d expected 0", exp_q.size());
    end
    summary();
  end

endmodule